// File: doc/BRIEF.md
# Cascaded 16-bit Pulse Accumulator

This block counts activity on a single external input pin in a 16-bit count built from two chained 8-bit byte counters. The pin first passes through a two-flop synchroniser. The synchronised level and its rising and falling edges then drive the count.

The block has two modes. In event mode the count advances on the chosen edge of the pin. In gated mode it advances on a tick made by dividing the system clock by 64, but only while the pin sits at the chosen level. The tick exists only while the timer-enable input is high. In both modes the chosen edge raises an edge flag. In gated mode that edge is the trailing edge of the gate. A wrap of the count from 0xFFFF to 0x0000 raises an overflow flag.

A small byte-wide register port holds the control register, the flags and the two count bytes. Each flag has its own interrupt output.

Top module: `pacc16_top`

## Requirements
- R1: After reset, the control register reads 0x00, the flags read 0x00, both count bytes read 0x00, and both interrupt outputs are low.
- R2: Register addresses are: 0 = control, 1 = flags, 2 = count high byte, 3 = count low byte. Control bit 7 always reads 0. Control bits 6:0 are read/write at any time, with this layout:
  - bit 6: accumulator enable
  - bit 5: mode (0 = event, 1 = gated)
  - bit 4: polarity
  - bits 3:2: stored only
  - bit 1: overflow interrupt enable
  - bit 0: edge interrupt enable
- R3: In event mode with the enable set, a polarity of 0 counts falling edges of the pin and a polarity of 1 counts rising edges. A pin change driven before clock edge k is counted at edge k+2.
- R4: In gated mode with the enable set, the count advances once per divide-by-64 tick. This happens only while the synchronised pin is high (polarity 0) or low (polarity 1).
- R5: While the timer enable is low, no tick is produced and gated mode holds its count. Event mode still counts.
- R6: The edge flag (flags bit 0) is set by the synchronised falling edge (polarity 0) or rising edge (polarity 1), in either mode. It is never set while the enable is clear.
- R7: The low byte carries into the high byte when it steps from 0xFF to 0x00.
- R8: A step of the count from 0xFFFF to 0x0000 sets the overflow flag (flags bit 1).
- R9: Writing 1 to a flag bit at address 1 clears that flag. Writing 0 leaves it unchanged. If the flag is set and cleared in the same cycle, the set wins.
- R10: Each interrupt output is high exactly when its flag and its enable bit (control bit 1 for overflow, bit 0 for edge) are both 1.
- R11: A write to a count byte loads that byte. Any step due in the same cycle is dropped, and the other byte keeps its value.
- R12: While the enable is clear, the count changes only through byte writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Timer enable; the divide-by-64 tick runs only while it is high |
| pa_pin | input | 1 | Asynchronous accumulator input pin |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on address) |
| irq_ovf | output | 1 | Overflow interrupt |
| irq_edge | output | 1 | Edge interrupt |

## Verification
Two pairs of functions can fall in the same cycle.

- A count step can meet a write to a count byte. The bench provokes this by changing the pin, then timing a low-byte write to land exactly on the clock edge two cycles after the pin change reaches the first synchroniser flop. It is judged by reading back the written byte and an unchanged high byte.
- An edge-flag set can meet a write-1-to-clear of that flag. The bench provokes this with the same timing and judges it by the flag reading 1 afterwards.

A behavioural model compares every register read and both interrupts on every clock.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_CHI  = 2'd2;
  localparam logic [1:0] ADDR_CLO  = 2'd3;

  typedef struct packed {
    logic       en;
    logic       gated;
    logic       pol;
    logic [1:0] clksel;
    logic       ovf_ie;
    logic       edg_ie;
  } ctrl_t;

  // selected edge: pol=0 -> falling, pol=1 -> rising
  function automatic logic pick_edge(input logic pol, input logic rise, input logic fall);
    return pol ? rise : fall;
  endfunction

  // gate open level: pol=0 -> high, pol=1 -> low
  function automatic logic gate_open(input logic pol, input logic level);
    return pol ? ~level : level;
  endfunction
endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin};
  end

  assign level = sh_q[STAGES-1];
  assign rise  = level & ~sh_q[STAGES];
  assign fall  = ~level & sh_q[STAGES];

  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n) rise |=> !rise);
  assert_fall_single_R3: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !fall);
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tmr_en,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !tmr_en) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = tmr_en && (cnt_q == LAST);

  assert_tick_spaced_R4: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
  assert_no_tick_off_R5: assert property (@(posedge clk) disable iff (!rst_n) !tmr_en |=> !tick);
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inc,
  input  logic [NBYTES-1:0]          wr_sel,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [NBYTES*BYTE_W-1:0]   count,
  output logic                       wrap
);
  logic [NBYTES:0] carry;

  assign carry[0] = inc & ~(|wr_sel);

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] b_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         b_q <= '0;
      else if (wr_sel[i]) b_q <= wdata;
      else if (carry[i])  b_q <= b_q + 1'b1;
    end
    assign carry[i+1] = carry[i] & (&b_q);
    assign count[i*BYTE_W +: BYTE_W] = b_q;
  end

  assign wrap = carry[NBYTES];

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && wr_sel == '0) |=> $stable(count));
  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[0] |=> count[BYTE_W-1:0] == $past(wdata));
  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> count == '0);
endmodule

// File: rtl/pacc16_top.sv
module pacc16_top
  import pacc_pkg::*;
#(
  parameter int PRE_DIV     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tmr_en,
  input  logic       pa_pin,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq_ovf,
  output logic       irq_edge
);
  localparam int NBYTES = 2;
  localparam int CNT_W  = NBYTES * REG_W;

  ctrl_t ctrl_q;
  logic  flg_ovf_q, flg_edge_q;

  logic pin_level, pin_rise, pin_fall, pre_tick;
  logic sel_edge, edge_evt, cnt_inc, ovf_evt;
  logic ctrl_wr, flag_wr;
  logic [NBYTES-1:0] cnt_wr;
  logic [CNT_W-1:0]  count;
  logic unused_wbit;

  assign unused_wbit = bus_wdata[7];

  pacc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pa_pin),
    .level(pin_level), .rise(pin_rise), .fall(pin_fall)
  );

  pacc_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .tick(pre_tick)
  );

  assign ctrl_wr   = bus_we && (bus_addr == ADDR_CTRL);
  assign flag_wr   = bus_we && (bus_addr == ADDR_FLAG);
  assign cnt_wr[1] = bus_we && (bus_addr == ADDR_CHI);
  assign cnt_wr[0] = bus_we && (bus_addr == ADDR_CLO);

  assign sel_edge = pick_edge(ctrl_q.pol, pin_rise, pin_fall);
  assign edge_evt = ctrl_q.en & sel_edge;
  assign cnt_inc  = ctrl_q.en & (ctrl_q.gated ? (pre_tick & gate_open(ctrl_q.pol, pin_level))
                                              : sel_edge);

  pacc_counter #(.BYTE_W(REG_W), .NBYTES(NBYTES)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .wr_sel(cnt_wr),
    .wdata(bus_wdata), .count(count), .wrap(ovf_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata[6:0]);
  end

  // write-1-to-clear, set has priority
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg_ovf_q  <= 1'b0;
      flg_edge_q <= 1'b0;
    end else begin
      if (flag_wr && bus_wdata[1]) flg_ovf_q  <= 1'b0;
      if (flag_wr && bus_wdata[0]) flg_edge_q <= 1'b0;
      if (ovf_evt)  flg_ovf_q  <= 1'b1;
      if (edge_evt) flg_edge_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = {1'b0, ctrl_q};
      ADDR_FLAG: bus_rdata = {6'b0, flg_ovf_q, flg_edge_q};
      ADDR_CHI:  bus_rdata = count[CNT_W-1 -: REG_W];
      default:   bus_rdata = count[REG_W-1:0];
    endcase
  end

  assign irq_ovf  = flg_ovf_q  & ctrl_q.ovf_ie;
  assign irq_edge = flg_edge_q & ctrl_q.edg_ie;

  assert_ovf_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flg_ovf_q);
  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> flg_edge_q);
  assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && bus_wdata[1] && !ovf_evt) |=> !flg_ovf_q);
  assert_edge_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !flg_edge_q && !ctrl_wr) |=> !flg_edge_q);
  assert_disabled_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && cnt_wr == '0) |=> $stable(count));
endmodule

// File: tb/pacc16_top_tb.sv
module pacc16_top_tb;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n, tmr_en, pin, we;
  logic [1:0] addr;
  logic [7:0] wd;
  logic [7:0] rd;
  logic irq_o, irq_e;

  int total = 0, bad = 0;
  bit done = 0;
  string cur_req = "R1";

  // reference model state
  bit [6:0] m_ctrl;
  bit m_ovf, m_edg, p1, p2, p3;
  int m_cnt, m_pre;

  pacc16_top u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .pa_pin(pin),
    .bus_we(we), .bus_addr(addr), .bus_wdata(wd), .bus_rdata(rd),
    .irq_ovf(irq_o), .irq_edge(irq_e)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_read(logic [1:0] a);
    case (a)
      2'd0: return int'(m_ctrl);
      2'd1: return (int'(m_ovf) << 1) | int'(m_edg);
      2'd2: return (m_cnt >> 8) & 255;
      default: return m_cnt & 255;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_ovf = 0; m_edg = 0; m_cnt = 0; m_pre = 0;
      p1 = 0; p2 = 0; p3 = 0;
    end else begin
      bit rise, fall, tick, en, gated, pol, ev, inc, cwr, ovf_set, edg_set;
      rise  = p2 && !p3;
      fall  = !p2 && p3;
      tick  = tmr_en && (m_pre == 63);
      en    = m_ctrl[6]; gated = m_ctrl[5]; pol = m_ctrl[4];
      ev    = pol ? rise : fall;
      inc   = en && (gated ? (tick && (p2 == !pol)) : ev);
      cwr   = we && (addr >= 2);
      ovf_set = inc && !cwr && (m_cnt == 16'hFFFF);
      edg_set = en && ev;
      if (cwr) begin
        if (addr == 2) m_cnt = (int'(wd) << 8) | (m_cnt & 255);
        else           m_cnt = (m_cnt & 16'hFF00) | int'(wd);
      end else if (inc) m_cnt = (m_cnt + 1) % 65536;
      if (we && addr == 1) begin
        if (wd[1]) m_ovf = 0;
        if (wd[0]) m_edg = 0;
      end
      if (ovf_set) m_ovf = 1;
      if (edg_set) m_edg = 1;
      if (we && addr == 0) m_ctrl = wd[6:0];
      m_pre = tmr_en ? ((m_pre == 63) ? 0 : m_pre + 1) : 0;
      p3 = p2; p2 = p1; p1 = pin;
    end
    #(CLK_P/4);
    if (rst_n && !done) begin
      check({cur_req, " model-read"}, int'(rd), model_read(addr));
      check("R10 irq_ovf", int'(irq_o), int'(m_ovf && m_ctrl[1]));
      check("R10 irq_edge", int'(irq_e), int'(m_edg && m_ctrl[0]));
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1; addr = a; wd = d;
    step();
    we = 0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string req);
    addr = a; #1;
    check(req, int'(rd), int'(exp));
  endtask

  task automatic pulse_pin(int n);
    for (int i = 0; i < n; i++) begin
      pin = 1; step(4);
      pin = 0; step(4);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; tmr_en = 0; pin = 0; we = 0; addr = 0; wd = 0;
    step(3);
    rst_n = 1; tmr_en = 1;
    step();
    // R1 reset state
    rd_chk(0, 8'h00, "R1 ctrl"); rd_chk(1, 8'h00, "R1 flags");
    rd_chk(2, 8'h00, "R1 cnt hi"); rd_chk(3, 8'h00, "R1 cnt lo");
    check("R1 irq", int'({irq_o, irq_e}), 0);

    cur_req = "R2";
    wr(0, 8'hFF); rd_chk(0, 8'h7F, "R2 bit7 reads 0");
    wr(0, 8'h2C); rd_chk(0, 8'h2C, "R2 readback");

    cur_req = "R3";
    wr(0, 8'h41);               // enable, event, falling, edge irq on
    pulse_pin(5); step(4);
    rd_chk(3, 8'd5, "R3 falling count"); rd_chk(2, 8'd0, "R3 high byte");
    rd_chk(1, 8'h01, "R6 edge flag set");
    check("R10 irq_edge asserted", int'(irq_e), 1);
    wr(1, 8'h01); rd_chk(1, 8'h00, "R9 edge flag cleared");

    wr(0, 8'h51);               // rising
    pulse_pin(3); step(4);
    rd_chk(3, 8'd8, "R3 rising count");

    cur_req = "R12";
    wr(0, 8'h11); wr(1, 8'h03);
    pulse_pin(3); step(4);
    rd_chk(3, 8'd8, "R12 disabled hold");
    rd_chk(1, 8'h00, "R6 no flag when disabled");

    cur_req = "R4";
    wr(2, 8'h00); wr(3, 8'h00);
    wr(0, 8'h60);               // gated, high level
    pin = 1; step(256);
    pin = 0; step(200);
    rd_chk(3, 8'd4, "R4 gated high 256 cycles");
    wr(1, 8'h03);
    wr(0, 8'h70);               // gated, low level; pin 0 opens gate
    pin = 1; step(100);
    pin = 0; step(256);
    pin = 1; step(150);
    rd_chk(3, 8'd8, "R4 gated low 256 cycles");
    rd_chk(1, 8'h01, "R6 trailing rising edge flag");

    cur_req = "R5";
    tmr_en = 0; pin = 0; step(300);
    rd_chk(3, 8'd8, "R5 gated frozen without timer");
    wr(0, 8'h50);
    pulse_pin(2); step(4);
    rd_chk(3, 8'd10, "R5 event counts without timer");
    tmr_en = 1;

    cur_req = "R7";
    wr(2, 8'h00); wr(3, 8'hFF);
    pulse_pin(1); step(4);
    rd_chk(2, 8'h01, "R7 carry high"); rd_chk(3, 8'h00, "R7 carry low");

    cur_req = "R8";
    wr(1, 8'h03);
    wr(0, 8'h52);
    wr(2, 8'hFF); wr(3, 8'hFE);
    pulse_pin(2); step(4);
    rd_chk(2, 8'h00, "R8 wrap high"); rd_chk(3, 8'h00, "R8 wrap low");
    rd_chk(1, 8'h03, "R8 overflow flag");
    check("R10 irq_ovf asserted", int'(irq_o), 1);
    wr(0, 8'h50);
    check("R10 irq_ovf masked", int'(irq_o), 0);

    cur_req = "R11";
    pin = 1; step(); step();
    wr(3, 8'h40);               // lands on the step edge
    pin = 0; step(4);
    rd_chk(3, 8'h40, "R11 write wins low"); rd_chk(2, 8'h00, "R11 high kept");

    cur_req = "R9";
    wr(1, 8'h03); step(4);
    pin = 1; step(); step();
    wr(1, 8'h01);               // clear on the set edge
    step(3);
    rd_chk(1, 8'h01, "R9 set beats clear");
    wr(1, 8'h01); rd_chk(1, 8'h00, "R9 clear alone");
    pin = 0; step(6);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule